// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block models the output cells of a sum-of-products programmable logic device. Each cell receives the OR-gate sum built by a product-term array, a dedicated output-enable product term and the value seen on its pin. It returns a pin drive value, a tri-state enable and one feedback signal that re-enters the array. A static configuration vector sets, per cell, whether the pin is driven from a flip-flop or straight from the sum, whether that drive is inverted, where the feedback comes from, and how the enable behaves.

The bidirectional pad is split into separate in, out and enable signals. All cells share one clock, one power-on reset and one asynchronous clear term. The cell count is a parameter, and the cells are built by a generate loop. Feedback has three independent sources: the pin, the register Q and the raw sum. The enable can be forced on, which gives a dedicated output, or forced off, which gives a dedicated input. Together with the output options this yields twelve useful operating configurations per cell.

Top module: `pld_mc_top`

## Requirements
- R1: While `rst_ni` is low every cell register is cleared, and it stays cleared until the first rising clock edge after release. A registered, non-inverted cell therefore drives `pin_o` = 0, and register feedback reads 0.
- R2: With configuration bit 0 (`registered`) = 1, the register captures `sum_i` on each rising edge of `clk_i`. `pin_o` then shows the captured value (XOR polarity) until the next edge.
- R3: With configuration bit 0 = 0, `pin_o` follows `sum_i` (XOR polarity) in the same cycle, with no clock involved.
- R4: Configuration bit 1 (`invert`) = 1 inverts `pin_o` in both the registered and the combinatorial path. Feedback is never inverted.
- R5: Configuration bits [3:2] select the feedback `fb_o`: 2'b00 and 2'b11 take `pin_i`, 2'b01 takes the register Q, and 2'b10 takes the raw `sum_i`.
- R6: Configuration bits [5:4] set the enable. 2'b01 forces `pin_oe_o` = 1 (dedicated output). 2'b10 forces `pin_oe_o` = 0 (dedicated input). 2'b00 and 2'b11 pass `oe_term_i`.
- R7: While `aclr_i` is high, every register is cleared at once without a clock edge. It stays cleared across rising edges and captures again on the first edge after `aclr_i` falls.
- R8: Sum feedback follows `sum_i` even when the output is disabled and the cell is registered, so a latch can be formed behind a disabled pin.
- R9: Register feedback keeps the last captured value while the pin is driven combinatorially from a changed sum.
- R10: Each cell uses only its own configuration field `cfg_i[i*6 +: 6]` and its own sum, enable-term and pin bits. Cells with different settings do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| cfg_i | input | N_CELLS*6 | Static per-cell configuration, 6 bits per cell |
| sum_i | input | N_CELLS | OR-gate sum per cell from the product-term array |
| oe_term_i | input | N_CELLS | Output-enable product term per cell |
| aclr_i | input | 1 | Asynchronous clear term, active high |
| pin_i | input | N_CELLS | Value observed on each pin |
| pin_o | output | N_CELLS | Pin drive value |
| pin_oe_o | output | N_CELLS | Pin tri-state enable, 1 drives |
| fb_o | output | N_CELLS | Feedback into the product-term array |

## Verification
The bench builds the block with the default of two cells. It gives the second cell the first cell's configuration with the registered and polarity bits flipped, and drives it with complemented stimulus. This makes any leakage between cells visible in every vector. All 64 encodings of the six-bit configuration are covered, including the reserved feedback and enable codes. Each encoding is run against four sum, enable-term and pin patterns, so that the register value, the live sum and the pin always differ in some vector. Directed steps cover reset release before the first edge, an asynchronous clear applied between edges and held across one, and latch-style sum feedback behind a disabled pin.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    localparam int CFG_W = 6;

    typedef enum logic [1:0] {
        FB_PIN     = 2'b00,
        FB_REG     = 2'b01,
        FB_SUM     = 2'b10,
        FB_PIN_ALT = 2'b11
    } fb_sel_e;

    typedef enum logic [1:0] {
        OE_TERM     = 2'b00,
        OE_ON       = 2'b01,
        OE_OFF      = 2'b10,
        OE_TERM_ALT = 2'b11
    } oe_mode_e;

    // packed: first field is the most significant
    typedef struct packed {
        oe_mode_e oe_mode;    // [5:4]
        fb_sel_e  fb_sel;     // [3:2]
        logic     invert;     // [1]
        logic     registered; // [0]
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_state_t;

endpackage

// File: rtl/pld_mc_reg.sv
module pld_mc_reg
    import pld_mc_pkg::*;
(
    input  logic clk_i,
    input  logic clr_ni,
    input  logic d_i,
    output logic q_o
);

    cell_state_t state_d;
    cell_state_t state_q;

    always_comb begin
        state_d   = state_q;
        state_d.q = d_i;
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.q;

endmodule

// File: rtl/pld_mc_out.sv
module pld_mc_out (
    input  logic registered_i,
    input  logic invert_i,
    input  logic sum_i,
    input  logic q_i,
    output logic pin_o
);

    logic raw;

    always_comb begin
        raw   = registered_i ? q_i : sum_i;
        pin_o = invert_i ? ~raw : raw;
    end

endmodule

// File: rtl/pld_mc_oe.sv
module pld_mc_oe
    import pld_mc_pkg::*;
(
    input  oe_mode_e mode_i,
    input  logic     term_i,
    output logic     oe_o
);

    always_comb begin
        unique case (mode_i)
            OE_ON:   oe_o = 1'b1;
            OE_OFF:  oe_o = 1'b0;
            default: oe_o = term_i;
        endcase
    end

endmodule

// File: rtl/pld_mc_fb.sv
module pld_mc_fb
    import pld_mc_pkg::*;
(
    input  fb_sel_e sel_i,
    input  logic    pin_i,
    input  logic    q_i,
    input  logic    sum_i,
    output logic    fb_o
);

    always_comb begin
        unique case (sel_i)
            FB_REG:  fb_o = q_i;
            FB_SUM:  fb_o = sum_i;   // bypasses the output buffer entirely
            default: fb_o = pin_i;
        endcase
    end

endmodule

// File: rtl/pld_mc_cell.sv
module pld_mc_cell
    import pld_mc_pkg::*;
(
    input  logic      clk_i,
    input  logic      clr_ni,
    input  cell_cfg_t cfg_i,
    input  logic      sum_i,
    input  logic      oe_term_i,
    input  logic      pin_i,
    output logic      pin_o,
    output logic      pin_oe_o,
    output logic      fb_o
);

    logic q;

    pld_mc_reg u_reg (
        .clk_i  (clk_i),
        .clr_ni (clr_ni),
        .d_i    (sum_i),
        .q_o    (q)
    );

    pld_mc_out u_out (
        .registered_i (cfg_i.registered),
        .invert_i     (cfg_i.invert),
        .sum_i        (sum_i),
        .q_i          (q),
        .pin_o        (pin_o)
    );

    pld_mc_oe u_oe (
        .mode_i (cfg_i.oe_mode),
        .term_i (oe_term_i),
        .oe_o   (pin_oe_o)
    );

    pld_mc_fb u_fb (
        .sel_i (cfg_i.fb_sel),
        .pin_i (pin_i),
        .q_i   (q),
        .sum_i (sum_i),
        .fb_o  (fb_o)
    );

endmodule

// File: rtl/pld_mc_top.sv
module pld_mc_top
    import pld_mc_pkg::*;
#(
    parameter int N_CELLS = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [N_CELLS*CFG_W-1:0] cfg_i,
    input  logic [N_CELLS-1:0]       sum_i,
    input  logic [N_CELLS-1:0]       oe_term_i,
    input  logic                     aclr_i,
    input  logic [N_CELLS-1:0]       pin_i,
    output logic [N_CELLS-1:0]       pin_o,
    output logic [N_CELLS-1:0]       pin_oe_o,
    output logic [N_CELLS-1:0]       fb_o
);

    localparam int CFG_TOTAL = N_CELLS * CFG_W;

    logic clr_n;
    assign clr_n = rst_ni & ~aclr_i;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_cfg_t cell_cfg;
        assign cell_cfg = cell_cfg_t'(cfg_i[i*CFG_W +: CFG_W]);

        pld_mc_cell u_cell (
            .clk_i     (clk_i),
            .clr_ni    (clr_n),
            .cfg_i     (cell_cfg),
            .sum_i     (sum_i[i]),
            .oe_term_i (oe_term_i[i]),
            .pin_i     (pin_i[i]),
            .pin_o     (pin_o[i]),
            .pin_oe_o  (pin_oe_o[i]),
            .fb_o      (fb_o[i])
        );
    end

    if (CFG_TOTAL != N_CELLS * CFG_W) begin : g_bad_cfg
        $error("configuration width mismatch");
    end

endmodule

// File: rtl/pld_mc_checker.sv
module pld_mc_checker
    import pld_mc_pkg::*;
#(
    parameter int N_CELLS = 2
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [N_CELLS*CFG_W-1:0] cfg_i,
    input logic [N_CELLS-1:0]       sum_i,
    input logic                     aclr_i,
    input logic [N_CELLS-1:0]       pin_o,
    input logic [N_CELLS-1:0]       pin_oe_o,
    input logic [N_CELLS-1:0]       fb_o
);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
        cell_cfg_t c;
        assign c = cell_cfg_t'(cfg_i[i*CFG_W +: CFG_W]);

        // R2: registered pin shows the sum sampled one edge earlier
        a_r2_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c.registered && !c.invert && !aclr_i)
            |=> (aclr_i || !$stable(cfg_i) || pin_o[i] == $past(sum_i[i])));

        // R3, R4: combinatorial pin tracks the sum with polarity
        a_r3_comb_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!c.registered) |-> (pin_o[i] == (sum_i[i] ^ c.invert)));

        // R6: forced enable modes
        a_r6_oe_forced_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c.oe_mode == OE_ON) |-> pin_oe_o[i]);

        a_r6_oe_forced_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c.oe_mode == OE_OFF) |-> !pin_oe_o[i]);

        // R7: clear holds the register at zero
        a_r7_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (aclr_i && c.registered) |-> (pin_o[i] == c.invert));

        // R5, R8: sum feedback follows the sum regardless of enable
        a_r8_sum_feedback: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c.fb_sel == FB_SUM) |-> (fb_o[i] == sum_i[i]));
    end

endmodule

bind pld_mc_top pld_mc_checker #(.N_CELLS(N_CELLS)) u_pld_mc_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg_i),
    .sum_i    (sum_i),
    .aclr_i   (aclr_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o),
    .fb_o     (fb_o)
);

// File: tb/test_pld_mc_top.sv
`timescale 1ns/1ps
module test_pld_mc_top;

    localparam int N = 2;
    localparam int CW = 6;
    // stimulus patterns {s_a, s_b, oe_term, pin}
    localparam logic [3:0] PAT [4] = '{4'b1010, 4'b0101, 4'b1100, 4'b0011};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*CW-1:0] cfg = '0;
    logic [N-1:0]    sum = '0;
    logic [N-1:0]    oet = '0;
    logic            aclr = 1'b0;
    logic [N-1:0]    pin = '0;
    logic [N-1:0]    pin_o, pin_oe, fb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pld_mc_top #(.N_CELLS(N)) i_pld_mc_top (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cfg_i     (cfg),
        .sum_i     (sum),
        .oe_term_i (oet),
        .aclr_i    (aclr),
        .pin_i     (pin),
        .pin_o     (pin_o),
        .pin_oe_o  (pin_oe),
        .fb_o      (fb)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // reference: returns {pin, oe, fb}; register holds s_a, live sum is s_b
    function automatic logic [2:0] ref_cell(logic [5:0] c, logic sa, logic sb,
                                            logic ot, logic pn);
        logic p, e, f;
        p = (c[0] ? sa : sb) ^ c[1];
        case (c[5:4])
            2'b01:   e = 1'b1;
            2'b10:   e = 1'b0;
            default: e = ot;
        endcase
        case (c[3:2])
            2'b01:   f = sa;
            2'b10:   f = sb;
            default: f = pn;
        endcase
        return {p, e, f};
    endfunction

    initial begin
        // R1: reset state, registered non-inverted, register feedback
        cfg = {6'b01_01_0_1, 6'b01_01_0_1};
        sum = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(pin_o[0], 1'b0, "R1 pin after reset");
        check(fb[0],    1'b0, "R1 reg feedback after reset");
        check(pin_o[1], 1'b0, "R1 pin cell1 after reset");
        @(posedge clk); #1;
        check(pin_o[0], 1'b1, "R2 first capture");

        // table walk: every encoding, four patterns, two cells
        for (int k = 0; k < 64; k++) begin
            for (int p = 0; p < 4; p++) begin
                logic [5:0] c0, c1;
                logic [3:0] p0, p1;
                logic [2:0] e0, e1;
                c0 = 6'(k);
                c1 = c0 ^ 6'b000011;
                p0 = PAT[p];
                p1 = ~PAT[p];
                @(negedge clk);
                cfg = {c1, c0};
                sum = {p1[3], p0[3]};
                oet = {p1[1], p0[1]};
                pin = {p1[0], p0[0]};
                @(posedge clk); #1;
                sum = {p1[2], p0[2]};
                #0.5;
                e0 = ref_cell(c0, p0[3], p0[2], p0[1], p0[0]);
                e1 = ref_cell(c1, p1[3], p1[2], p1[1], p1[0]);
                check(pin_o[0], e0[2], c0[1] ? "R4 pin polarity" : (c0[0] ? "R2 pin reg" : "R3 pin comb"));
                check(pin_oe[0], e0[1], "R6 enable");
                check(fb[0], e0[0], (c0[3:2] == 2'b01 && !c0[0]) ? "R9 reg feedback" : "R5 feedback");
                check(pin_o[1], e1[2], "R10 cell1 pin");
                check(pin_oe[1], e1[1], "R10 cell1 enable");
                check(fb[1], e1[0], "R10 cell1 feedback");
            end
        end

        // R7: asynchronous clear between edges, held across one edge
        @(negedge clk);
        cfg = {6'b01_01_0_1, 6'b01_01_0_1};
        sum = '1;
        @(posedge clk); #1;
        check(pin_o[0], 1'b1, "R7 pre-clear capture");
        aclr = 1'b1;
        #0.5;
        check(pin_o[0], 1'b0, "R7 clear without edge");
        check(fb[0],    1'b0, "R7 reg feedback cleared");
        @(posedge clk); #1;
        check(pin_o[1], 1'b0, "R7 clear held across edge");
        aclr = 1'b0;
        #0.5;
        check(pin_o[0], 1'b0, "R7 stays clear until edge");
        @(posedge clk); #1;
        check(pin_o[0], 1'b1, "R7 capture after release");

        // R8: latch-style sum feedback behind a disabled registered pin
        @(negedge clk);
        cfg = {6'b10_10_0_1, 6'b10_10_0_1};
        oet = '1;
        for (int t = 0; t < 4; t++) begin
            sum = N'(t);
            #0.5;
            check(fb[0], t[0], "R8 sum feedback while disabled");
            check(pin_oe[0], 1'b0, "R8 enable forced off");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule